// File: doc/BRIEF.md
# Operand and Effective Address Resolver

This unit sits between an instruction decoder and an execution stage. For each request it takes the mode field, a register-select field and a short address field, and returns one of two results. The first is an operand, for the modes that carry their data inside the instruction or in a register. The second is an effective address, for the modes that point at memory. It owns a small register file, which is loaded from outside through a write port. The post-increment and pre-decrement modes update that register file by themselves.

Indirect mode needs one extra word from memory. The unit raises a memory request and holds its address steady until the memory answers with ready. The word that comes back is the effective address. All other modes finish one clock after the request is accepted. Each finished request produces a one-cycle `done` pulse, with two flags that say which result is valid. The program counter (already advanced past the current instruction), an index register, a base register and an accumulator/top-of-stack value all come in as plain inputs.

Top module: `addr_mode_unit`

## Requirements
- R1: After a synchronous active-low reset, `done`, `busy` and `mem_req` are low and every internal register reads as zero.
- R2: Mode 4'b0000 (implied) returns `operand` = `acc_tos` with `has_opd`=1 and `has_ea`=0. Like every accepted non-indirect request, it raises `done` for exactly the one cycle after the `start` cycle.
- R3: Mode 4'b0001 (immediate) returns `operand` = the zero-extended address field with `has_opd`=1, and raises no memory request.
- R4: Mode 4'b0010 (register) returns `operand` = register `reg_sel`. A register written through `rf_we`/`rf_waddr`/`rf_wdata` holds the new value from the next cycle on.
- R5: Mode 4'b0011 (register indirect) returns `ea` = register `reg_sel` with `has_ea`=1, and leaves the register unchanged.
- R6: Mode 4'b0100 (post-increment) returns `ea` = the old register value and writes old+1 (modulo 2^W) back into the register.
- R7: Mode 4'b0101 (pre-decrement) writes old-1 (modulo 2^W) into the register and returns that same decremented value as `ea`.
- R8: Mode 4'b0110 (direct) returns `ea` = the zero-extended field. Mode 4'b1001 (indexed) returns `xr` + the zero-extended field. Mode 4'b1010 (base) returns `br` + the zero-extended field. All sums are taken modulo 2^W.
- R9: Mode 4'b1000 (relative) returns `ea` = `pc_next` + the sign-extended field, modulo 2^W.
- R10: Mode 4'b0111 (indirect) raises `mem_req`, with `mem_addr` = the zero-extended field held stable, until a cycle with `mem_ready`=1. In the cycle after that, `done`=1, `has_ea`=1, `ea` = the `mem_rdata` sampled in the ready cycle, and `mem_req` is low.
- R11: While `busy` is high, `start` is ignored: no result and no register write-back comes from it.
- R12: When a post-increment or pre-decrement write-back and an external write target the same register in the same cycle, the write-back value is the one kept.
- R13: Mode codes 4'b1011 to 4'b1111 complete in one cycle with `has_ea`=0 and `has_opd`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request valid; accepted when `busy` is low |
| mode | input | 4 | Addressing mode code |
| reg_sel | input | K | Register file index |
| addr_field | input | FW | Instruction address field |
| pc_next | input | W | Program counter, already past the current instruction |
| xr | input | W | Index register value |
| br | input | W | Base register value |
| acc_tos | input | W | Accumulator or top-of-stack value for implied mode |
| rf_we | input | 1 | External register write enable |
| rf_waddr | input | K | External register write index |
| rf_wdata | input | W | External register write data |
| mem_req | output | 1 | Indirect fetch request |
| mem_addr | output | W | Indirect fetch address |
| mem_rdata | input | W | Indirect fetch data |
| mem_ready | input | 1 | Indirect fetch completion |
| busy | output | 1 | Indirect fetch in progress |
| done | output | 1 | One-cycle result valid pulse |
| has_ea | output | 1 | `ea` is valid with this `done` |
| has_opd | output | 1 | `operand` is valid with this `done` |
| ea | output | W | Effective address |
| operand | output | W | Operand |

## Verification
The bench drives the wrap-around edges: post-increment of 16'hFFFF must give zero, and pre-decrement of zero must give 16'hFFFF. A design that uses the wrong order, address before the update or after it, returns an address off by one in one of these two modes. A negative relative field shows whether sign extension is applied; a design that zero-extends would land 256 words too high. The indirect fetch is stretched over several wait cycles while a competing `start` is held high; a design that does not hold its address, or that accepts the second request, shows it as a moving `mem_addr` or as a changed register. A write-back that collides with an external write to the same register shows whether the update from the addressing mode wins.

// File: rtl/amu_pkg.sv
// Package: mode codes shared by the operand/effective-address resolver.
// Assumes a 4-bit mode field; codes above MODE_BASE are unused.
package amu_pkg;
    localparam int MODE_W = 4;
    localparam logic [MODE_W-1:0] MODE_IMPL = 4'h0;
    localparam logic [MODE_W-1:0] MODE_IMM  = 4'h1;
    localparam logic [MODE_W-1:0] MODE_REG  = 4'h2;
    localparam logic [MODE_W-1:0] MODE_RIND = 4'h3;
    localparam logic [MODE_W-1:0] MODE_AINC = 4'h4;
    localparam logic [MODE_W-1:0] MODE_ADEC = 4'h5;
    localparam logic [MODE_W-1:0] MODE_DIR  = 4'h6;
    localparam logic [MODE_W-1:0] MODE_IND  = 4'h7;
    localparam logic [MODE_W-1:0] MODE_REL  = 4'h8;
    localparam logic [MODE_W-1:0] MODE_IDX  = 4'h9;
    localparam logic [MODE_W-1:0] MODE_BASE = 4'hA;
endpackage

// File: rtl/amu_regfile.sv
// Module: small register file with one asynchronous read port and two write
// sources. The mode write-back has priority over the external write port.
// Assumes 2**K registers, all cleared by reset.
module amu_regfile #(
    parameter int W = 16,
    parameter int K = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [K-1:0] raddr,
    output logic [W-1:0] rdata,
    input  logic         wb_en,
    input  logic [K-1:0] wb_addr,
    input  logic [W-1:0] wb_data,
    input  logic         ext_we,
    input  logic [K-1:0] ext_addr,
    input  logic [W-1:0] ext_wdata
);
    localparam int N = 1 << K;

    logic [W-1:0] regs [N];

    for (genvar i = 0; i < N; i++) begin : g_reg
        // Purpose: update one register, write-back first, then external data.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (wb_en && (wb_addr == K'(i)))
                regs[i] <= wb_data;
            else if (ext_we && (ext_addr == K'(i)))
                regs[i] <= ext_wdata;
        end
    end

    // Purpose: combinational read of the selected register.
    assign rdata = regs[raddr];

    // R12
    wb_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> regs[$past(wb_addr)] == $past(wb_data));
endmodule

// File: rtl/amu_calc.sv
// Module: combinational mode decode. Forms the operand or effective address,
// the register write-back for the update modes, and the indirect-fetch flag.
// Assumes W > FW; the field is sign-extended only for relative mode.
module amu_calc
    import amu_pkg::*;
#(
    parameter int W  = 16,
    parameter int FW = 8
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [FW-1:0]     field,
    input  logic [W-1:0]      reg_val,
    input  logic [W-1:0]      pc_next,
    input  logic [W-1:0]      xr,
    input  logic [W-1:0]      br,
    input  logic [W-1:0]      acc_tos,
    output logic              r_has_ea,
    output logic              r_has_opd,
    output logic [W-1:0]      r_ea,
    output logic [W-1:0]      r_opd,
    output logic              wb_req,
    output logic [W-1:0]      wb_val,
    output logic              go_ind,
    output logic [W-1:0]      ind_addr
);
    localparam int EXT = W - FW;

    logic [W-1:0] zext;
    logic [W-1:0] sext;

    assign zext     = {{EXT{1'b0}}, field};
    assign sext     = {{EXT{field[FW-1]}}, field};
    assign ind_addr = zext;

    // Purpose: select result kind and value for the presented mode.
    always_comb begin
        r_has_ea  = 1'b0;
        r_has_opd = 1'b0;
        r_ea      = '0;
        r_opd     = '0;
        wb_req    = 1'b0;
        wb_val    = '0;
        go_ind    = 1'b0;
        case (mode)
            MODE_IMPL: begin r_has_opd = 1'b1; r_opd = acc_tos; end
            MODE_IMM:  begin r_has_opd = 1'b1; r_opd = zext;    end
            MODE_REG:  begin r_has_opd = 1'b1; r_opd = reg_val; end
            MODE_RIND: begin r_has_ea  = 1'b1; r_ea  = reg_val; end
            MODE_AINC: begin
                r_has_ea = 1'b1;
                r_ea     = reg_val;
                wb_req   = 1'b1;
                wb_val   = reg_val + W'(1);
            end
            MODE_ADEC: begin
                r_has_ea = 1'b1;
                r_ea     = reg_val - W'(1);
                wb_req   = 1'b1;
                wb_val   = reg_val - W'(1);
            end
            MODE_DIR:  begin r_has_ea = 1'b1; r_ea = zext;           end
            MODE_IND:  begin go_ind   = 1'b1;                        end
            MODE_REL:  begin r_has_ea = 1'b1; r_ea = pc_next + sext; end
            MODE_IDX:  begin r_has_ea = 1'b1; r_ea = xr + zext;      end
            MODE_BASE: begin r_has_ea = 1'b1; r_ea = br + zext;      end
            default:   ;
        endcase
    end
endmodule

// File: rtl/amu_indirect.sv
// Module: memory-indirect fetch sequencer. Holds the request and its address
// from launch until a ready cycle, then reports completion for one cycle.
// Assumes the memory returns data in the same cycle it asserts ready.
module amu_indirect #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         launch,
    input  logic [W-1:0] launch_addr,
    input  logic         mem_ready,
    output logic         mem_req,
    output logic [W-1:0] mem_addr,
    output logic         fin
);
    logic         waiting;
    logic [W-1:0] addr_q;

    // Purpose: track the outstanding fetch and latch its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting <= 1'b0;
            addr_q  <= '0;
        end else if (waiting) begin
            if (mem_ready) waiting <= 1'b0;
        end else if (launch) begin
            waiting <= 1'b1;
            addr_q  <= launch_addr;
        end
    end

    assign mem_req  = waiting;
    assign mem_addr = addr_q;
    assign fin      = waiting && mem_ready;

    // R10
    ind_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));
endmodule

// File: rtl/addr_mode_unit.sv
// Module: top of the operand/effective-address resolver. Accepts a request
// when idle, registers the result so done follows start by one cycle, and
// routes the indirect mode through the fetch sequencer.
// Assumes start is ignored while busy; the outputs hold between done pulses.
module addr_mode_unit
    import amu_pkg::*;
#(
    parameter int W  = 16,
    parameter int FW = 8,
    parameter int K  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic [K-1:0]      reg_sel,
    input  logic [FW-1:0]     addr_field,
    input  logic [W-1:0]      pc_next,
    input  logic [W-1:0]      xr,
    input  logic [W-1:0]      br,
    input  logic [W-1:0]      acc_tos,
    input  logic              rf_we,
    input  logic [K-1:0]      rf_waddr,
    input  logic [W-1:0]      rf_wdata,
    output logic              mem_req,
    output logic [W-1:0]      mem_addr,
    input  logic [W-1:0]      mem_rdata,
    input  logic              mem_ready,
    output logic              busy,
    output logic              done,
    output logic              has_ea,
    output logic              has_opd,
    output logic [W-1:0]      ea,
    output logic [W-1:0]      operand
);
    logic         accept;
    logic [W-1:0] reg_val;
    logic         c_has_ea, c_has_opd, c_wb, c_ind;
    logic [W-1:0] c_ea, c_opd, c_wb_val, c_ind_addr;
    logic         ind_fin;

    assign busy   = mem_req;
    assign accept = start && !busy;

    amu_regfile #(.W(W), .K(K)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .raddr(reg_sel), .rdata(reg_val),
        .wb_en(accept && c_wb), .wb_addr(reg_sel), .wb_data(c_wb_val),
        .ext_we(rf_we), .ext_addr(rf_waddr), .ext_wdata(rf_wdata)
    );

    amu_calc #(.W(W), .FW(FW)) u_calc (
        .mode(mode), .field(addr_field), .reg_val(reg_val),
        .pc_next(pc_next), .xr(xr), .br(br), .acc_tos(acc_tos),
        .r_has_ea(c_has_ea), .r_has_opd(c_has_opd),
        .r_ea(c_ea), .r_opd(c_opd),
        .wb_req(c_wb), .wb_val(c_wb_val),
        .go_ind(c_ind), .ind_addr(c_ind_addr)
    );

    amu_indirect #(.W(W)) u_ind (
        .clk(clk), .rst_n(rst_n),
        .launch(accept && c_ind), .launch_addr(c_ind_addr),
        .mem_ready(mem_ready),
        .mem_req(mem_req), .mem_addr(mem_addr), .fin(ind_fin)
    );

    // Purpose: register the result and produce the one-cycle done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            has_ea  <= 1'b0;
            has_opd <= 1'b0;
            ea      <= '0;
            operand <= '0;
        end else begin
            done <= 1'b0;
            if (ind_fin) begin
                done    <= 1'b1;
                has_ea  <= 1'b1;
                has_opd <= 1'b0;
                ea      <= mem_rdata;
            end else if (accept && !c_ind) begin
                done    <= 1'b1;
                has_ea  <= c_has_ea;
                has_opd <= c_has_opd;
                ea      <= c_ea;
                operand <= c_opd;
            end
        end
    end

    // R2
    one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode != MODE_IND) |=> done);

    // R10
    ind_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> (done && has_ea && !mem_req));

    // R11
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    // R13
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(has_ea && has_opd));
endmodule

// File: tb/addr_mode_unit_tb.sv
module addr_mode_unit_tb;
    localparam int W = 16, FW = 8, K = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0;
    logic [3:0] mode = '0;
    logic [K-1:0] reg_sel = '0;
    logic [FW-1:0] addr_field = '0;
    logic [W-1:0] pc_next = 16'h0100, xr = 16'h2000, br = 16'h4000, acc_tos = 16'hA5A5;
    logic rf_we = 1'b0;
    logic [K-1:0] rf_waddr = '0;
    logic [W-1:0] rf_wdata = '0;
    logic mem_req, busy, done, has_ea, has_opd;
    logic [W-1:0] mem_addr, ea, operand;
    logic [W-1:0] mem_rdata = '0;
    logic mem_ready = 1'b0;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;
    logic [W-1:0] model_rf [8];

    always #5 clk = ~clk;

    addr_mode_unit #(.W(W), .FW(FW), .K(K)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .reg_sel(reg_sel),
        .addr_field(addr_field), .pc_next(pc_next), .xr(xr), .br(br), .acc_tos(acc_tos),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .busy(busy), .done(done), .has_ea(has_ea), .has_opd(has_opd),
        .ea(ea), .operand(operand)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference: expected result of a one-cycle mode from the model state.
    task automatic ref_mode(input logic [3:0] m, input logic [2:0] s, input logic [7:0] f,
                            output logic xe, output logic xo, output logic [W-1:0] vea,
                            output logic [W-1:0] vop);
        logic [W-1:0] z, sx, r;
        z = {8'h00, f};
        sx = {{8{f[7]}}, f};
        r = model_rf[s];
        xe = 0; xo = 0; vea = 'x; vop = 'x;
        case (m)
            4'd0: begin xo = 1; vop = acc_tos; end
            4'd1: begin xo = 1; vop = z; end
            4'd2: begin xo = 1; vop = r; end
            4'd3: begin xe = 1; vea = r; end
            4'd4: begin xe = 1; vea = r; model_rf[s] = r + 16'd1; end
            4'd5: begin xe = 1; model_rf[s] = r - 16'd1; vea = model_rf[s]; end
            4'd6: begin xe = 1; vea = z; end
            4'd8: begin xe = 1; vea = pc_next + sx; end
            4'd9: begin xe = 1; vea = xr + z; end
            4'd10: begin xe = 1; vea = br + z; end
            default: ;
        endcase
    endtask

    task automatic run_op(input string req, input logic [3:0] m, input logic [2:0] s, input logic [7:0] f);
        logic xe, xo;
        logic [W-1:0] vea, vop;
        @(negedge clk);
        start = 1; mode = m; reg_sel = s; addr_field = f;
        ref_mode(m, s, f, xe, xo, vea, vop);
        @(negedge clk);
        start = 0;
        chk(req, "done", done, 1);
        chk(req, "has_ea", has_ea, xe);
        chk(req, "has_opd", has_opd, xo);
        if (xe) chk(req, "ea", ea, vea);
        if (xo) chk(req, "operand", operand, vop);
        chk(req, "mem_req", mem_req, 0);
        @(negedge clk);
        chk(req, "done pulse end", done, 0);
    endtask

    task automatic wr(input logic [2:0] s, input logic [W-1:0] v);
        @(negedge clk);
        rf_we = 1; rf_waddr = s; rf_wdata = v;
        model_rf[s] = v;
        @(negedge clk);
        rf_we = 0;
    endtask

    // Indirect fetch with wait cycles; optionally hold a competing start high.
    task automatic run_ind(input logic [7:0] f, input logic [W-1:0] word, input int waits, input bit compete);
        @(negedge clk);
        start = 1; mode = 4'd7; addr_field = f;
        @(negedge clk);
        if (compete) begin mode = 4'd4; reg_sel = 3'd1; end
        else start = 0;
        for (int i = 0; i < waits; i++) begin
            chk("R10", "mem_req wait", mem_req, 1);
            chk("R10", "mem_addr", mem_addr, {8'h00, f});
            chk("R11", "busy/done", {busy, done}, 2'b10);
            @(negedge clk);
        end
        chk("R10", "mem_req last", mem_req, 1);
        mem_ready = 1; mem_rdata = word;
        @(negedge clk);
        start = 0; mem_ready = 0; mem_rdata = 16'hDEAD;
        chk("R10", "done", done, 1);
        chk("R10", "has_ea/has_opd", {has_ea, has_opd}, 2'b10);
        chk("R10", "ea", ea, word);
        chk("R10", "mem_req drop", mem_req, 0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) model_rf[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "done", done, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "mem_req", mem_req, 0);
        run_op("R1", 4'd2, 3'd5, 8'h00);
        run_op("R2", 4'd0, 3'd0, 8'h33);
        acc_tos = 16'h0F0F;
        run_op("R2", 4'd0, 3'd0, 8'h33);
        run_op("R3", 4'd1, 3'd0, 8'hC7);
        wr(3'd2, 16'h1234);
        run_op("R4", 4'd2, 3'd2, 8'h00);
        run_op("R5", 4'd3, 3'd2, 8'h00);
        run_op("R5", 4'd2, 3'd2, 8'h00);
        wr(3'd3, 16'hFFFF);
        run_op("R6", 4'd4, 3'd3, 8'h00);
        run_op("R6", 4'd4, 3'd3, 8'h00);
        run_op("R6", 4'd2, 3'd3, 8'h00);
        run_op("R7", 4'd5, 3'd4, 8'h00);
        run_op("R7", 4'd5, 3'd4, 8'h00);
        run_op("R7", 4'd2, 3'd4, 8'h00);
        run_op("R8", 4'd6, 3'd0, 8'h9A);
        run_op("R8", 4'd9, 3'd0, 8'h9A);
        br = 16'hFFF0;
        run_op("R8", 4'd10, 3'd0, 8'h20);
        run_op("R9", 4'd8, 3'd0, 8'h10);
        run_op("R9", 4'd8, 3'd0, 8'hF0);
        pc_next = 16'h0005;
        run_op("R9", 4'd8, 3'd0, 8'h80);
        run_ind(8'h44, 16'hBEEF, 0, 0);
        run_ind(8'h81, 16'h0777, 4, 0);
        // R11: start held with post-increment on reg 1 during the fetch
        wr(3'd1, 16'h0050);
        run_ind(8'h12, 16'h3030, 3, 1);
        @(negedge clk);
        run_op("R11", 4'd2, 3'd1, 8'h00);
        // R12: external write collides with post-increment on reg 6
        wr(3'd6, 16'h0100);
        @(negedge clk);
        start = 1; mode = 4'd4; reg_sel = 3'd6;
        rf_we = 1; rf_waddr = 3'd6; rf_wdata = 16'h7777;
        model_rf[6] = 16'h0101;
        @(negedge clk);
        start = 0; rf_we = 0;
        chk("R12", "ea", ea, 16'h0100);
        run_op("R12", 4'd2, 3'd6, 8'h00);
        run_op("R13", 4'd11, 3'd0, 8'h01);
        run_op("R13", 4'd15, 3'd0, 8'hFF);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule